// File: doc/BRIEF.md
# Serial Pattern-Load Column Register

This block keeps one column of calibration pattern data inside a DRAM device before that data is written to the core. Training logic sends a stream of one-byte load packets. Each packet moves the whole holding register up by one byte and puts the new byte at the bottom. Thirty-two packets fill a column of sixteen 16-bit words. The same packet type serves every device width.

Once the column is loaded, the host issues write commands that carry two sub-column select bits, sel = SC[3:2]. Each command copies the held words to the core word array through a fixed scrambled slot order. A per-word enable mask, decoded from the programmed width and the select bits, picks which core words the command writes. A narrow device therefore needs several commands, one per sub-column, to place the whole column.

A synchronous clear empties the register and restarts the byte count. A sticky warning flag records any write command issued before the column was complete.

Top module: `plr_column_reg`

## Requirements
- R1: While reset is asserted and right after it is released, `core_we`, `col_full` and `early_wr` are all zero.
- R2: Each load packet shifts the register up by 8 bits and puts the new byte in the lowest byte. Serial word k is made of bytes 2k and 2k+1 of the column. The earlier of the two bytes forms bits [15:8] of the word.
- R3: Serial word k is delivered to core slot m, which occupies `core_wdata[16m+15:16m]`. The mapping k→m is 0→15, 1→7, 2→11, 3→3, 4→13, 5→5, 6→9, 7→1, 8→0, 9→8, 10→4, 11→12, 12→2, 13→10, 14→6, 15→14.
- R4: When `wmode` is 00 (x16), a write command raises all 16 bits of `core_we`, whatever the value of `wr_sel`.
- R5: When `wmode` is 01 (x8), `wr_sel[1]` chooses the half: 0 enables slots 0..7 and 1 enables slots 8..15. `wr_sel[0]` has no effect.
- R6: When `wmode` is 10 (x4), `wr_sel` chooses a quarter: 00 enables slots 0..3, 01 enables 4..7, 10 enables 8..11 and 11 enables 12..15.
- R7: When `wmode` is 11, which is not a supported width, a write command raises no enable.
- R8: `core_we` and `core_wdata` change on the clock edge that samples `wr_vld`. The data is the register content from before that edge. `core_we` is zero in every cycle after an edge that saw no write command.
- R9: `col_full` goes high on the edge that takes the 32nd byte since the last clear and then stays high. The byte count wraps at 32, and further bytes keep shifting the register.
- R10: `clr` zeroes the register, the byte count, `col_full` and `early_wr` on the next edge. Clear takes priority over a load in the same cycle.
- R11: A write command given while `col_full` is low still writes the current register content, and it sets `early_wr`. That flag stays set until the next clear or reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of the column, the byte count and the flags |
| ld_vld | input | 1 | Load packet strobe |
| ld_byte | input | 8 | Byte carried by the load packet |
| wmode | input | 2 | Device width: 00 x16, 01 x8, 10 x4, 11 unsupported |
| wr_vld | input | 1 | Write command strobe |
| wr_sel | input | 2 | Sub-column select bits SC[3:2] |
| core_we | output | 16 | Per-slot core write enables |
| core_wdata | output | 256 | Core words in slot order, slot m at bits [16m+15:16m] |
| col_full | output | 1 | Column complete since the last clear |
| early_wr | output | 1 | Sticky flag: a write command came before the column was complete |

## Verification
Directed columns of counting bytes make every word distinct. With those columns, a single x16 write shows whether each serial word lands in its own slot and whether the bytes inside each word are in the right order. The x8 and x4 writes go through every select value, including the ignored bit. Each write is compared against the whole enable pattern, so a wrong half, a wrong quarter or a swapped bit stands out, and the unsupported code must give an empty mask. Random columns, with an occasional byte beyond 32, check the shift path once the count has wrapped. Writes issued right after a clear separate the empty-register data from the sticky warning flag.

// File: rtl/plr_pkg.sv
package plr_pkg;

    typedef enum logic [1:0] {
        MODE_X16 = 2'b00,
        MODE_X8  = 2'b01,
        MODE_X4  = 2'b10,
        MODE_BAD = 2'b11
    } width_mode_e;

    // Core slot that receives serial word k of an n-word column.
    // The low bits of k are bit-reversed and doubled. The lower half of the
    // serial order counts down from the top slot; the upper half counts up
    // from slot zero.
    function automatic int slot_of(input int k, input int n);
        int lb;
        int low;
        int rev;
        lb  = $clog2(n) - 1;
        low = k % (n / 2);
        rev = 0;
        for (int i = 0; i < lb; i++) begin
            if (((low >> i) & 1) != 0) begin
                rev = rev | (1 << (lb - 1 - i));
            end
        end
        if (k >= n / 2) begin
            return 2 * rev;
        end
        return n - 1 - 2 * rev;
    endfunction

endpackage

// File: rtl/plr_shift_reg.sv
module plr_shift_reg #(
    parameter int COL_W  = 256,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              ld_vld,
    input  logic [BYTE_W-1:0] ld_byte,
    output logic [COL_W-1:0]  col,
    output logic              full
);
    localparam int NBYTES = COL_W / BYTE_W;
    localparam int CNT_W  = $clog2(NBYTES);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

    typedef struct packed {
        logic [COL_W-1:0] col;
        logic [CNT_W-1:0] cnt;
        logic             full;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr) begin
            st_d.col  = '0;
            st_d.cnt  = '0;
            st_d.full = 1'b0;
        end else if (ld_vld) begin
            st_d.col = {st_q.col[COL_W-BYTE_W-1:0], ld_byte};
            if (st_q.cnt == LAST) begin
                st_d.cnt  = '0;
                st_d.full = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign col  = st_q.col;
    assign full = st_q.full;

endmodule

// File: rtl/plr_scramble.sv
module plr_scramble #(
    parameter int WORD_W = 16,
    parameter int NWORDS = 16
) (
    input  logic [WORD_W*NWORDS-1:0] serial_col,
    output logic [WORD_W*NWORDS-1:0] slot_col
);
    localparam int COL_W = WORD_W * NWORDS;

    for (genvar k = 0; k < NWORDS; k++) begin : g_word
        localparam int SLOT = plr_pkg::slot_of(k, NWORDS);
        assign slot_col[SLOT*WORD_W +: WORD_W] =
            serial_col[COL_W-1-k*WORD_W -: WORD_W];
    end

endmodule

// File: rtl/plr_sc_mask.sv
module plr_sc_mask #(
    parameter int NWORDS = 16
) (
    input  plr_pkg::width_mode_e mode,
    input  logic [1:0]           sel,
    output logic [NWORDS-1:0]    mask
);
    import plr_pkg::*;

    localparam int QUARTER = NWORDS / 4;

    for (genvar w = 0; w < NWORDS; w++) begin : g_slot
        localparam logic [1:0] QTR = 2'(w / QUARTER);
        assign mask[w] = (mode == MODE_X16)
                       | ((mode == MODE_X8) && (sel[1] == QTR[1]))
                       | ((mode == MODE_X4) && (sel == QTR));
    end

endmodule

// File: rtl/plr_column_reg.sv
module plr_column_reg #(
    parameter int WORD_W = 16,
    parameter int NWORDS = 16,
    parameter int BYTE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic                     ld_vld,
    input  logic [BYTE_W-1:0]        ld_byte,
    input  logic [1:0]               wmode,
    input  logic                     wr_vld,
    input  logic [1:0]               wr_sel,
    output logic [NWORDS-1:0]        core_we,
    output logic [WORD_W*NWORDS-1:0] core_wdata,
    output logic                     col_full,
    output logic                     early_wr
);
    import plr_pkg::*;

    localparam int COL_W = WORD_W * NWORDS;

    typedef struct packed {
        logic [NWORDS-1:0] we;
        logic [COL_W-1:0]  data;
        logic              warn;
    } out_state_t;

    out_state_t        os_d, os_q;
    logic [COL_W-1:0]  serial_col;
    logic [COL_W-1:0]  slot_col;
    logic [NWORDS-1:0] sc_mask;
    logic              full;

    plr_shift_reg #(.COL_W(COL_W), .BYTE_W(BYTE_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (clr),
        .ld_vld  (ld_vld),
        .ld_byte (ld_byte),
        .col     (serial_col),
        .full    (full)
    );

    plr_scramble #(.WORD_W(WORD_W), .NWORDS(NWORDS)) u_scr (
        .serial_col (serial_col),
        .slot_col   (slot_col)
    );

    plr_sc_mask #(.NWORDS(NWORDS)) u_mask (
        .mode (width_mode_e'(wmode)),
        .sel  (wr_sel),
        .mask (sc_mask)
    );

    always_comb begin
        os_d    = os_q;
        os_d.we = '0;
        if (wr_vld) begin
            os_d.we   = sc_mask;
            os_d.data = slot_col;
        end
        if (clr) begin
            os_d.warn = 1'b0;
        end else if (wr_vld && !full) begin
            os_d.warn = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            os_q <= '0;
        end else begin
            os_q <= os_d;
        end
    end

    assign core_we    = os_q.we;
    assign core_wdata = os_q.data;
    assign col_full   = full;
    assign early_wr   = os_q.warn;

endmodule

// File: rtl/plr_column_reg_chk.sv
module plr_column_reg_chk #(
    parameter int NWORDS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clr,
    input logic              ld_vld,
    input logic [1:0]        wmode,
    input logic              wr_vld,
    input logic [1:0]        wr_sel,
    input logic [NWORDS-1:0] core_we,
    input logic              col_full,
    input logic              early_wr
);
    localparam int QUARTER = NWORDS / 4;

    always_comb begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (core_we == '0 && !col_full && !early_wr); // R1
        end
    end

    AST_X16_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wmode == 2'b00) |=> (core_we == {NWORDS{1'b1}})); // R4

    AST_X8_HALF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wmode == 2'b01) |=> ($countones(core_we) == NWORDS / 2)); // R5

    AST_X4_QUARTER: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wmode == 2'b10) |=> ($countones(core_we) == QUARTER)); // R6

    AST_BAD_MODE_NONE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && wmode == 2'b11) |=> (core_we == '0)); // R7

    AST_IDLE_NO_WE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_vld |=> (core_we == '0)); // R8

    AST_FULL_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (col_full && !clr) |=> col_full); // R9

    AST_FULL_NEEDS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (!col_full && !ld_vld) |=> !col_full); // R9

    AST_CLR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!col_full && !early_wr)); // R10

    AST_EARLY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_vld && !col_full && !clr) |=> early_wr); // R11

    AST_FLAG_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
        (early_wr && !clr) |=> early_wr); // R11

    logic unused_sel;
    assign unused_sel = ^wr_sel;

endmodule

bind plr_column_reg plr_column_reg_chk #(.NWORDS(NWORDS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (clr),
    .ld_vld   (ld_vld),
    .wmode    (wmode),
    .wr_vld   (wr_vld),
    .wr_sel   (wr_sel),
    .core_we  (core_we),
    .col_full (col_full),
    .early_wr (early_wr)
);

// File: tb/sim_plr_column_reg.sv
`timescale 1ns/1ps
module sim_plr_column_reg;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         clr = 1'b0;
    logic         ld_vld = 1'b0;
    logic [7:0]   ld_byte = '0;
    logic [1:0]   wmode = '0;
    logic         wr_vld = 1'b0;
    logic [1:0]   wr_sel = '0;
    logic [15:0]  core_we;
    logic [255:0] core_wdata;
    logic         col_full;
    logic         early_wr;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    logic [255:0] mreg = '0;
    int           mcnt = 0;
    bit           mfull = 1'b0;
    bit           mwarn = 1'b0;

    always #4 clk = ~clk;

    plr_column_reg u0 (
        .clk(clk), .rst_n(rst_n), .clr(clr), .ld_vld(ld_vld), .ld_byte(ld_byte),
        .wmode(wmode), .wr_vld(wr_vld), .wr_sel(wr_sel), .core_we(core_we),
        .core_wdata(core_wdata), .col_full(col_full), .early_wr(early_wr)
    );

    function automatic int exp_slot(input int k);
        case (k)
            0: return 15;  1: return 7;   2: return 11;  3: return 3;
            4: return 13;  5: return 5;   6: return 9;   7: return 1;
            8: return 0;   9: return 8;   10: return 4;  11: return 12;
            12: return 2;  13: return 10; 14: return 6;  default: return 14;
        endcase
    endfunction

    function automatic logic [15:0] exp_mask(input logic [1:0] m, input logic [1:0] s);
        case (m)
            2'b00: return 16'hFFFF;
            2'b01: return s[1] ? 16'hFF00 : 16'h00FF;
            2'b10: return 16'h000F << (4 * s);
            default: return 16'h0000;
        endcase
    endfunction

    function automatic logic [255:0] exp_slots(input logic [255:0] r);
        logic [255:0] o = '0;
        for (int k = 0; k < 16; k++) begin
            o[exp_slot(k)*16 +: 16] = r[255-16*k -: 16];
        end
        return o;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_byte(input logic [7:0] b);
        @(negedge clk);
        ld_vld = 1'b1;
        ld_byte = b;
        mreg = {mreg[247:0], b};
        mcnt++;
        if (mcnt == 32) begin
            mcnt = 0;
            mfull = 1'b1;
        end
        @(posedge clk);
        #1;
        ld_vld = 1'b0;
    endtask

    task automatic do_clr();
        @(negedge clk);
        clr = 1'b1;
        mreg = '0; mcnt = 0; mfull = 1'b0; mwarn = 1'b0;
        @(posedge clk);
        #1;
        clr = 1'b0;
        chk(col_full == 1'b0 && early_wr == 1'b0, "R10", "flags after clear",
            {col_full, early_wr}, 0);
    endtask

    task automatic do_write(input logic [1:0] m, input logic [1:0] s, input string req);
        logic [15:0]  em;
        logic [255:0] ed;
        em = exp_mask(m, s);
        ed = exp_slots(mreg);
        @(negedge clk);
        wmode = m; wr_sel = s; wr_vld = 1'b1;
        if (!mfull) mwarn = 1'b1;
        @(posedge clk);
        #1;
        wr_vld = 1'b0;
        chk(core_we == em, req, "write enables", core_we, em);
        for (int w = 0; w < 16; w++) begin
            if (em[w]) begin
                chk(core_wdata[w*16 +: 16] == ed[w*16 +: 16], "R3", $sformatf("slot %0d data", w),
                    core_wdata[w*16 +: 16], ed[w*16 +: 16]);
            end
        end
        chk(early_wr == mwarn, "R11", "early write flag", early_wr, mwarn);
        @(posedge clk);
        #1;
        chk(core_we == 16'h0000, "R8", "enables drop after write", core_we, 0);
    endtask

    initial begin
        #(8 * 100000);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(posedge clk);
        #1;
        chk(core_we == 0 && !col_full && !early_wr, "R1", "state in reset",
            {core_we, col_full, early_wr}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk(core_we == 0 && !col_full && !early_wr, "R1", "state after reset",
            {core_we, col_full, early_wr}, 0);

        // R2 R9: counting bytes, fullness edge at byte 32
        for (int i = 0; i < 31; i++) load_byte(8'(i + 1));
        chk(col_full == 1'b0, "R9", "not full after 31 bytes", col_full, 0);
        load_byte(8'd32);
        chk(col_full == 1'b1, "R9", "full after 32 bytes", col_full, 1);
        // R2 R3 R4: serial word 0 = 0x0102 lands in slot 15
        do_write(2'b00, 2'b10, "R4");
        chk(core_wdata[255:240] == 16'h0102, "R2", "byte order word 0", core_wdata[255:240], 16'h0102);
        chk(core_wdata[15:0] == 16'h1112, "R2", "serial word 8 in slot 0", core_wdata[15:0], 16'h1112);
        do_write(2'b00, 2'b01, "R4");
        for (int s = 0; s < 4; s++) do_write(2'b01, 2'(s), "R5");
        for (int s = 0; s < 4; s++) do_write(2'b10, 2'(s), "R6");
        do_write(2'b11, 2'b00, "R7");
        do_write(2'b11, 2'b11, "R7");
        chk(early_wr == 1'b0, "R11", "no warning after full-column writes", early_wr, 0);

        // R9: bytes past 32 keep shifting
        load_byte(8'hA5);
        load_byte(8'h5A);
        chk(col_full == 1'b1, "R9", "stays full after wrap", col_full, 1);
        do_write(2'b00, 2'b00, "R9");

        // R10 R11: clear, then an early write of the empty register
        do_clr();
        do_write(2'b00, 2'b00, "R10");
        chk(core_wdata == '0, "R10", "cleared data", core_wdata, 0);
        load_byte(8'h77);
        do_write(2'b10, 2'b11, "R11");
        chk(early_wr == 1'b1, "R11", "flag stays set", early_wr, 1);

        // R10: clear wins over a load in the same cycle
        @(negedge clk);
        clr = 1'b1; ld_vld = 1'b1; ld_byte = 8'hEE;
        mreg = '0; mcnt = 0; mfull = 1'b0; mwarn = 1'b0;
        @(posedge clk);
        #1;
        clr = 1'b0; ld_vld = 1'b0;
        do_write(2'b00, 2'b00, "R10");

        // Random columns
        for (int r = 0; r < 30; r++) begin
            do_clr();
            for (int i = 0; i < 32; i++) load_byte(8'($urandom));
            if ($urandom % 4 == 0) load_byte(8'($urandom));
            for (int w = 0; w < 3; w++) do_write(2'($urandom), 2'($urandom), "R3");
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule